// File: doc/BRIEF.md
# Asynchronous Timer Register Bridge

This block lets a processor in a fast clock domain drive an 8-bit counter that runs on a separate, slow and unrelated clock. The counter, two compare values and two control values live in the slow domain. The processor writes to them through a small register port. Each write is posted: the bus cycle finishes at once, and the value then crosses into the slow domain through its own toggle handshake. While a value is still in transit, a per-register busy flag reads as 1.

The processor cannot sample the counter directly. It reads a copy held in the fast domain, and that copy is refreshed on every rising edge of the slow clock. A compare match in the slow domain toggles an output pin, if the pin is enabled, and flips a toggle line. That toggle line is synchronized into the fast domain, where it sets a sticky interrupt flag. Software clears a flag by writing 1 to it.

A status register holds two mode bits. One bit selects the external slow-clock input instead of the crystal path. The other bit starts the counter.

Top module: `async_tmr_bridge`

## Requirements
- R1: After reset, every readable register reads 0, both interrupt flags and both compare pins are 0, the crystal-enable output is 1 and the external-input enable is 0.
- R2: Status register (address 5): bit 7 reads 0; bit 6 is the external-clock select and bit 5 the run select, both read/write; bits 4..0 are the busy flags of counter, compare A, compare B, control A and control B, in that order from bit 4 down, and writes to them have no effect.
- R3: A write to address 0 (counter), 1 (compare A), 2 (compare B), 3 (control A) or 4 (control B) makes only that register's busy flag read 1 in the next cycle.
- R4: A busy flag stays set for at least two slow-clock periods after its write and clears no later than three slow-clock periods plus four fast cycles after it.
- R5: A write to a register whose busy flag is set leaves the flag set until the latest value has reached the slow domain; the slow-domain register ends up holding the latest value.
- R6: A read of address 0 returns a fast-domain copy of the counter. Each refresh of this copy changes it by at most one count while the counter runs.
- R7: The counter advances by one on each slow-clock rising edge while the run bit is 1, and holds its value while the run bit is 0.
- R8: When the counter equals compare A, flag bit 0 at address 6 is set; when it equals compare B, flag bit 1 is set. Writing 1 to a flag bit clears it, and writing 0 to it has no effect.
- R9: A flag becomes visible 1 to 5 fast cycles after its compare pin toggles, and by then the counter copy already reads at least the compare value plus one.
- R10: Compare pin A toggles on a compare-A match only while control A bit 0 is 1. Compare pin B toggles on a compare-B match only while control A bit 1 is 1.
- R11: The crystal-enable output is the inverse of the external-clock select. The external-input enable is 1 only when both the external-clock select and the run select are 1.
- R12: With control B bit 0 set, a compare-A match returns the counter to 0 on the next slow edge. The counter then never exceeds compare A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| slow_clk | input | 1 | Slow asynchronous counter clock |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| irq_o | output | 2 | Sticky compare-match flags (A in bit 0, B in bit 1) |
| cmp_out_o | output | 2 | Compare output pins, driven from the slow domain |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| ext_in_en_o | output | 1 | External slow-clock input buffer enable |

## Verification
Posted writes are exercised in three ways: a single write to an idle register, two back-to-back writes to the same register, and writes to several registers at once. These show whether busy timing is tracked per register and whether a second write is lost or merged. The counter copy is observed while the counter is held, while it runs freely and while it wraps on the compare-A match. These three cases separate a broken refresh path from a broken increment path or a broken clear path. Interrupt latency is timed against the compare-pin toggle, and flag clearing is checked with both 0 and 1 written per bit.

// File: rtl/tbr_pkg.sv
`timescale 1ns/1ps
package tbr_pkg;
    localparam int unsigned NREG = 5;
    localparam int unsigned NCMP = 2;

    localparam int unsigned I_CNT  = 0;
    localparam int unsigned I_CMPA = 1;
    localparam int unsigned I_CMPB = 2;
    localparam int unsigned I_CTLA = 3;
    localparam int unsigned I_CTLB = 4;

    localparam int unsigned ST_EXT      = 6;
    localparam int unsigned ST_RUN      = 5;
    localparam int unsigned ST_BUSY_TOP = 4;

    typedef enum logic [2:0] {
        RG_CNT  = 3'd0,
        RG_CMPA = 3'd1,
        RG_CMPB = 3'd2,
        RG_CTLA = 3'd3,
        RG_CTLB = 3'd4,
        RG_STAT = 3'd5,
        RG_FLAG = 3'd6
    } tbr_reg_e;
endpackage

// File: rtl/tbr_sync2.sv
`timescale 1ns/1ps
module tbr_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/tbr_post_cdc.sv
`timescale 1ns/1ps
module tbr_post_cdc #(
    parameter int unsigned DW = 8
) (
    input  logic          clk_f,
    input  logic          rst_f_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          busy_o,
    output logic [DW-1:0] last_o,
    output logic [DW-1:0] val_o,
    input  logic          clk_s,
    input  logic          rst_s_n,
    output logic          load_o
);
    typedef struct packed {
        logic [DW-1:0] hold;
        logic [DW-1:0] pend;
        logic          pend_v;
        logic          req;
    } fst_t;

    fst_t f_d, f_q;
    logic ack_f;
    logic req_s;
    logic ack_d, ack_q;
    logic idle;

    // fast side: the hold value stays still while a transfer is in flight
    always_comb begin
        f_d  = f_q;
        idle = (f_q.req == ack_f);
        if (wr_i) begin
            if (idle && !f_q.pend_v) begin
                f_d.hold = wdata_i;
                f_d.req  = ~f_q.req;
            end else begin
                f_d.pend   = wdata_i;
                f_d.pend_v = 1'b1;
            end
        end else if (idle && f_q.pend_v) begin
            f_d.hold   = f_q.pend;
            f_d.req    = ~f_q.req;
            f_d.pend_v = 1'b0;
        end
    end

    always_ff @(posedge clk_f or negedge rst_f_n) begin
        if (!rst_f_n) f_q <= '0;
        else          f_q <= f_d;
    end

    tbr_sync2 #(.W(1)) i_req_sync (
        .clk(clk_s), .rst_n(rst_s_n), .d_i(f_q.req), .q_o(req_s)
    );

    // slow side: a new request is taken and acknowledged in one edge
    always_comb begin
        ack_d  = req_s;
        load_o = req_s ^ ack_q;
    end

    always_ff @(posedge clk_s or negedge rst_s_n) begin
        if (!rst_s_n) ack_q <= 1'b0;
        else          ack_q <= ack_d;
    end

    tbr_sync2 #(.W(1)) i_ack_sync (
        .clk(clk_f), .rst_n(rst_f_n), .d_i(ack_q), .q_o(ack_f)
    );

    assign busy_o = (f_q.req != ack_f) || f_q.pend_v;
    assign val_o  = f_q.hold;
    assign last_o = f_q.pend_v ? f_q.pend : f_q.hold;

    p_busy_on_write_r3: assert property (@(posedge clk_f) disable iff (!rst_f_n)
        wr_i |=> busy_o);

    p_busy_kept_r5: assert property (@(posedge clk_f) disable iff (!rst_f_n)
        (wr_i && busy_o) |=> busy_o);

    p_single_load_r4: assert property (@(posedge clk_s) disable iff (!rst_s_n)
        load_o |=> !load_o);
endmodule

// File: rtl/tbr_slow_core.sv
`timescale 1ns/1ps
module tbr_slow_core
    import tbr_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic                      clk_s,
    input  logic                      rst_s_n,
    input  logic                      run_i,
    input  logic [NREG-1:0]           ld_i,
    input  logic [NREG-1:0][DW-1:0]   val_i,
    output logic [DW-1:0]             cnt_o,
    output logic                      tick_o,
    output logic [NCMP-1:0]           mt_o,
    output logic [NCMP-1:0]           oc_o
);
    typedef struct packed {
        logic [DW-1:0]            cnt;
        logic [NCMP-1:0][DW-1:0]  cmp;
        logic [DW-1:0]            ctla;
        logic [DW-1:0]            ctlb;
        logic                     tick;
        logic [NCMP-1:0]          mt;
        logic [NCMP-1:0]          oc;
    } slow_t;

    slow_t s_d, s_q;
    logic [NCMP-1:0] hit;
    logic wrap;
    logic unused_ctl;

    always_comb begin
        s_d      = s_q;
        s_d.tick = ~s_q.tick;
        for (int k = 0; k < NCMP; k++) begin
            hit[k] = run_i && (s_q.cnt == s_q.cmp[k]);
        end
        wrap     = hit[0] && s_q.ctlb[0];
        s_d.mt   = s_q.mt ^ hit;
        s_d.oc   = s_q.oc ^ (hit & s_q.ctla[NCMP-1:0]);
        if (ld_i[I_CNT]) begin
            s_d.cnt = val_i[I_CNT];
        end else if (run_i) begin
            s_d.cnt = wrap ? '0 : s_q.cnt + DW'(1);
        end
        if (ld_i[I_CMPA]) s_d.cmp[0] = val_i[I_CMPA];
        if (ld_i[I_CMPB]) s_d.cmp[1] = val_i[I_CMPB];
        if (ld_i[I_CTLA]) s_d.ctla   = val_i[I_CTLA];
        if (ld_i[I_CTLB]) s_d.ctlb   = val_i[I_CTLB];
    end

    always_ff @(posedge clk_s or negedge rst_s_n) begin
        if (!rst_s_n) s_q <= '0;
        else          s_q <= s_d;
    end

    assign cnt_o      = s_q.cnt;
    assign tick_o     = s_q.tick;
    assign mt_o       = s_q.mt;
    assign oc_o       = s_q.oc;
    assign unused_ctl = ^{s_q.ctla, s_q.ctlb};

    p_hold_stopped_r7: assert property (@(posedge clk_s) disable iff (!rst_s_n)
        (!run_i && !ld_i[I_CNT]) |=> (s_q.cnt == $past(s_q.cnt)));

    p_step_running_r7: assert property (@(posedge clk_s) disable iff (!rst_s_n)
        (run_i && !ld_i[I_CNT] && !wrap) |=> (s_q.cnt == $past(s_q.cnt) + DW'(1)));

    p_wrap_zero_r12: assert property (@(posedge clk_s) disable iff (!rst_s_n)
        (wrap && !ld_i[I_CNT]) |=> (s_q.cnt == '0));

    p_pin_gated_r10: assert property (@(posedge clk_s) disable iff (!rst_s_n)
        !s_q.ctla[0] |=> (s_q.oc[0] == $past(s_q.oc[0])));
endmodule

// File: rtl/async_tmr_bridge.sv
`timescale 1ns/1ps
module async_tmr_bridge
    import tbr_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slow_clk,
    input  logic          bus_we,
    input  logic [2:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [1:0]    irq_o,
    output logic [1:0]    cmp_out_o,
    output logic          xtal_en_o,
    output logic          ext_in_en_o
);
    typedef struct packed {
        logic            ext_en;
        logic            run;
        logic [NCMP-1:0] irq;
        logic [DW-1:0]   shadow;
        logic            tick_seen;
        logic [NCMP-1:0] mt_seen;
    } fast_t;

    fast_t f_d, f_q;

    logic                    rst_s_n;
    logic [NREG-1:0]         wr_v, busy_v, ld_v;
    logic [NREG-1:0][DW-1:0] val_v, last_v;
    logic [DW-1:0]           cnt_s;
    logic                    tick_s, tick_f, run_s;
    logic [NCMP-1:0]         mt_s, mt_f, set_v, clr_v;
    logic                    tick_evt;
    logic                    unused_bits;

    // slow-domain reset: asserted at once, released on slow edges
    tbr_sync2 #(.W(1)) i_rst_sync (
        .clk(slow_clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_s_n)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_post
        assign wr_v[g] = bus_we && (bus_addr == 3'(g));
        tbr_post_cdc #(.DW(DW)) i_post (
            .clk_f   (clk),
            .rst_f_n (rst_n),
            .wr_i    (wr_v[g]),
            .wdata_i (bus_wdata),
            .busy_o  (busy_v[g]),
            .last_o  (last_v[g]),
            .val_o   (val_v[g]),
            .clk_s   (slow_clk),
            .rst_s_n (rst_s_n),
            .load_o  (ld_v[g])
        );
    end

    tbr_sync2 #(.W(1)) i_run_sync (
        .clk(slow_clk), .rst_n(rst_s_n), .d_i(f_q.run), .q_o(run_s)
    );

    tbr_slow_core #(.DW(DW)) i_core (
        .clk_s   (slow_clk),
        .rst_s_n (rst_s_n),
        .run_i   (run_s),
        .ld_i    (ld_v),
        .val_i   (val_v),
        .cnt_o   (cnt_s),
        .tick_o  (tick_s),
        .mt_o    (mt_s),
        .oc_o    (cmp_out_o)
    );

    tbr_sync2 #(.W(1)) i_tick_sync (
        .clk(clk), .rst_n(rst_n), .d_i(tick_s), .q_o(tick_f)
    );

    tbr_sync2 #(.W(NCMP)) i_mt_sync (
        .clk(clk), .rst_n(rst_n), .d_i(mt_s), .q_o(mt_f)
    );

    always_comb begin
        f_d          = f_q;
        tick_evt     = (tick_f != f_q.tick_seen);
        set_v        = mt_f ^ f_q.mt_seen;
        clr_v        = '0;
        f_d.tick_seen = tick_f;
        f_d.mt_seen   = mt_f;
        if (tick_evt) f_d.shadow = cnt_s;
        if (bus_we && (bus_addr == RG_STAT)) begin
            f_d.ext_en = bus_wdata[ST_EXT];
            f_d.run    = bus_wdata[ST_RUN];
        end
        if (bus_we && (bus_addr == RG_FLAG)) clr_v = bus_wdata[NCMP-1:0];
        f_d.irq = (f_q.irq & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (tbr_reg_e'(bus_addr))
            RG_CNT:  bus_rdata = f_q.shadow;
            RG_CMPA: bus_rdata = last_v[I_CMPA];
            RG_CMPB: bus_rdata = last_v[I_CMPB];
            RG_CTLA: bus_rdata = last_v[I_CTLA];
            RG_CTLB: bus_rdata = last_v[I_CTLB];
            RG_STAT: begin
                bus_rdata[ST_EXT] = f_q.ext_en;
                bus_rdata[ST_RUN] = f_q.run;
                for (int i = 0; i < NREG; i++) begin
                    bus_rdata[ST_BUSY_TOP - i] = busy_v[i];
                end
            end
            RG_FLAG: bus_rdata[NCMP-1:0] = f_q.irq;
            default: bus_rdata = '0;
        endcase
    end

    assign irq_o       = f_q.irq;
    assign xtal_en_o   = ~f_q.ext_en;
    assign ext_in_en_o = f_q.ext_en & f_q.run;
    assign unused_bits = ^{last_v[I_CNT], bus_wdata};

    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_v[0] |=> irq_o[0]);

    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v[0] && !set_v[0]) |=> !irq_o[0]);

    p_shadow_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_evt |=> (f_q.shadow == $past(f_q.shadow)));
endmodule

// File: tb/test_async_tmr_bridge.sv
`timescale 1ns/1ps
module test_async_tmr_bridge;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          slow_clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [1:0]    irq_o, cmp_out_o;
    logic          xtal_en_o, ext_in_en_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;
    always #18.5 slow_clk = ~slow_clk;

    async_tmr_bridge #(.DW(DW)) i_async_tmr_bridge (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .cmp_out_o(cmp_out_o),
        .xtal_en_o(xtal_en_o), .ext_in_en_o(ext_in_en_o)
    );

    typedef struct {
        logic [2:0]    a;
        logic [DW-1:0] e;
        string         tag;
    } exp_t;
    exp_t sb_q[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected reads and compares them at the falling edge
    initial begin
        forever begin
            exp_t it;
            @(negedge clk);
            if (sb_q.size() > 0 && bus_addr == sb_q[0].a) begin
                it = sb_q.pop_front();
                chk(bus_rdata == it.e, it.tag, "read", int'(bus_rdata), int'(it.e));
            end
        end
    end

    task automatic expect_rd(input logic [2:0] a, input logic [DW-1:0] e, input string tag);
        exp_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.a = a; it.e = e; it.tag = tag;
        sb_q.push_back(it);
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic peek(input logic [2:0] a, output logic [DW-1:0] v);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic busy_cycles(input int bitpos, output int n);
        logic [DW-1:0] v;
        n = 0;
        peek(3'd5, v);
        while (v[bitpos] && n < 400) begin
            n++;
            peek(3'd5, v);
        end
    endtask

    task automatic idle_all();
        logic [DW-1:0] v;
        int guard;
        guard = 0;
        peek(3'd5, v);
        while ((v & 8'h1F) != 0 && guard < 1000) begin
            guard++;
            peek(3'd5, v);
        end
    endtask

    task automatic slow_wait(input int n);
        repeat (n) @(posedge slow_clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v, s1, s2, prev, mx;
        logic [1:0] oc0;
        int n, changes, stepbad;
        bit zero_seen;

        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        slow_wait(4);

        // R1: reset state
        for (int a = 0; a < 7; a++) expect_rd(3'(a), '0, "R1");
        chk(xtal_en_o == 1'b1 && ext_in_en_o == 1'b0, "R1", "clock enables",
            int'({xtal_en_o, ext_in_en_o}), 2);
        chk(irq_o == 2'b00 && cmp_out_o == 2'b00, "R1", "flags and pins",
            int'({irq_o, cmp_out_o}), 0);

        // R2 / R11: status layout and clock enables
        wr(3'd5, 8'hFF);
        expect_rd(3'd5, 8'h60, "R2");
        chk(xtal_en_o == 1'b0 && ext_in_en_o == 1'b1, "R11", "ext+run",
            int'({xtal_en_o, ext_in_en_o}), 1);
        wr(3'd5, 8'h40);
        chk(xtal_en_o == 1'b0 && ext_in_en_o == 1'b0, "R11", "ext only",
            int'({xtal_en_o, ext_in_en_o}), 0);
        wr(3'd5, 8'h00);
        expect_rd(3'd5, 8'h00, "R2");
        chk(xtal_en_o == 1'b1, "R11", "crystal back on", int'(xtal_en_o), 1);

        // R3 / R4: single posted write to compare A
        wr(3'd1, 8'h33);
        expect_rd(3'd5, 8'h08, "R3");
        busy_cycles(3, n);
        chk(n >= 14 && n <= 28, "R4", "busy cycles", n, 20);
        expect_rd(3'd1, 8'h33, "R3");

        // R5: overwrite while busy
        wr(3'd0, 8'd10);
        wr(3'd0, 8'd20);
        busy_cycles(4, n);
        chk(n >= 26, "R5", "busy cycles over two transfers", n, 30);
        slow_wait(3);
        expect_rd(3'd0, 8'd20, "R5");

        // R7: held while stopped
        slow_wait(10);
        expect_rd(3'd0, 8'd20, "R7");

        // R6 / R7: running
        wr(3'd5, 8'h20);
        slow_wait(20);
        peek(3'd0, v);
        chk(v >= 8'd35 && v <= 8'd40, "R7", "count after 20 slow edges", int'(v), 38);
        prev = v; changes = 0; stepbad = 0;
        for (int i = 0; i < 150; i++) begin
            peek(3'd0, v);
            if (v != prev) begin
                changes++;
                if (v != prev + 8'd1) stepbad++;
            end
            prev = v;
        end
        chk(stepbad == 0, "R6", "non-unit shadow steps", stepbad, 0);
        chk(changes >= 15 && changes <= 22, "R6", "refresh count", changes, 20);
        wr(3'd5, 8'h00);
        slow_wait(4);
        peek(3'd0, s1);
        slow_wait(10);
        peek(3'd0, s2);
        chk(s1 == s2, "R7", "stopped counter", int'(s2), int'(s1));

        // R8 / R9 / R10: compare matches
        wr(3'd1, 8'h40);
        wr(3'd2, 8'h48);
        wr(3'd3, 8'h01);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h38);
        idle_all();
        wr(3'd6, 8'h03);
        expect_rd(3'd6, 8'h00, "R8");
        oc0 = cmp_out_o;
        wr(3'd5, 8'h20);
        n = 0;
        while (cmp_out_o[0] == oc0[0] && n < 2000) begin
            @(negedge clk); n++;
        end
        chk(cmp_out_o[0] != oc0[0], "R10", "pin A toggled", int'(cmp_out_o[0]), int'(~oc0[0]));
        n = 0;
        while (!irq_o[0] && n < 20) begin
            @(negedge clk); n++;
        end
        chk(n >= 1 && n <= 5, "R9", "flag latency", n, 3);
        repeat (4) @(negedge clk);
        peek(3'd0, v);
        chk(v >= 8'h41 && v <= 8'h44, "R9", "counter advanced", int'(v), 8'h41);
        expect_rd(3'd6, 8'h01, "R8");
        n = 0;
        while (!irq_o[1] && n < 2000) begin
            @(negedge clk); n++;
        end
        chk(irq_o[1] == 1'b1, "R8", "flag B set", int'(irq_o[1]), 1);
        chk(cmp_out_o[1] == oc0[1], "R10", "pin B gated", int'(cmp_out_o[1]), int'(oc0[1]));
        wr(3'd5, 8'h00);
        wr(3'd6, 8'h00);
        expect_rd(3'd6, 8'h03, "R8");
        wr(3'd6, 8'h01);
        expect_rd(3'd6, 8'h02, "R8");
        wr(3'd6, 8'h02);
        expect_rd(3'd6, 8'h00, "R8");

        // R12: clear on compare A match, pins disabled
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h01);
        wr(3'd1, 8'h10);
        wr(3'd0, 8'h08);
        idle_all();
        oc0 = cmp_out_o;
        wr(3'd6, 8'h03);
        wr(3'd5, 8'h20);
        mx = '0; zero_seen = 1'b0;
        for (int i = 0; i < 300; i++) begin
            peek(3'd0, v);
            if (v > mx) mx = v;
            if (v == 8'h00) zero_seen = 1'b1;
        end
        chk(mx == 8'h10, "R12", "max count", int'(mx), 8'h10);
        chk(zero_seen, "R12", "wrapped to zero", int'(zero_seen), 1);
        chk(cmp_out_o == oc0, "R10", "pins quiet", int'(cmp_out_o), int'(oc0));
        chk(irq_o[0] == 1'b1, "R8", "flag A on wrap match", int'(irq_o[0]), 1);
        wr(3'd5, 8'h00);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule